// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects up to 32 level-sensitive interrupt request lines and hands the processor a single interrupt line plus the address of the routine that should service the most urgent request. A per-source enable mask selects which lines may interrupt. Sixteen vectored slots map enabled sources to handlers. Each slot holds a control word, which is an enable bit and a 5-bit source number, and a handler address. The lowest-numbered slot has the highest priority. An enabled request that no enabled slot claims is still serviced, and it gets a separate fallback address.

Software reads the vector register on entry to the interrupt routine. That read fixes the winning slot. The interrupt line then stays quiet and the register keeps returning the same address until software writes the same register to acknowledge the end of service. Enable bits are set through one register and cleared through another, so no read-modify-write sequence is needed. All registers sit on a simple word-addressed bus with write and read strobes. Reads are combinational.

Top module: `vic_core`

## Requirements
- R1: After reset, the interrupt line is low, the enable mask reads 0, and the vector register reads 0, which is the reset value of the fallback address.
- R2: Writing word address 0x00 sets every enable bit whose data bit is 1 and leaves the others unchanged. Bit n enables source n, so 0x00020000 enables source 17. Reading 0x00 returns the mask.
- R3: Writing word address 0x01 clears every enable bit whose data bit is 1 and leaves the others unchanged.
- R4: The slot control word at 0x10+n uses bit 5 as the slot enable and bits 4:0 as the bound source number, so 0x20|17 binds slot n to source 17. A slot whose bit 5 is 0 never matches a source. A slot's handler address is at 0x20+n.
- R5: The interrupt line is high in the same cycle that some source is both requesting and enabled, provided no service is outstanding. A requesting source that is not enabled does not raise it.
- R6: Reading the vector register at 0x03 returns the handler address of the lowest-numbered enabled slot whose bound source is requesting and enabled.
- R7: The vector register returns the fallback address, held at word 0x04, when no enabled slot matches. If an enabled source is requesting, that read starts a service. If no enabled source is requesting, the read starts no service and leaves the interrupt line unchanged.
- R8: A vector read taken while the interrupt line is high starts a service. The interrupt line then stays low, and later vector reads return the same address, until the acknowledge write. This holds even if a higher-priority request arrives or the original request drops.
- R9: Any write to word 0x03 ends the service. From the next cycle, the interrupt line again follows the requesting and enabled sources, and the next vector read picks a fresh winner.
- R10: Reading word 0x02 returns the bitwise AND of the request lines and the enable mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Interrupt request lines, active high, synchronous to clk_i |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe; a read of 0x03 can start a service |
| addr_i | input | 6 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The hardest situation to reach is a higher-priority request that arrives while a lower-priority service is outstanding. The bench starts a service on source 14, which is bound to slot 4. It then raises source 17, which is bound to slot 1. It checks that the interrupt line stays low and that the vector register still returns the slot 4 address. Only after the acknowledge write does the slot 1 address appear. Two further cases reach slot matching from less obvious directions. One disables a slot at run time, so its source falls through to the fallback address. The other rebinds the same source to a different slot.

// File: rtl/vic_core.sv
module vic_core #(
  parameter int NSRC   = 32,
  parameter int NSLOT  = 16,
  parameter int DW     = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              irq_o
);
  localparam int SRC_W  = $clog2(NSRC);
  localparam int SLOT_W = $clog2(NSLOT);
  localparam int CTL_W  = SRC_W + 1;
  localparam int LVL_W  = SLOT_W + 1;
  localparam logic [1:0] RG_CMN = 2'd0, RG_CTL = 2'd1, RG_ADR = 2'd2;
  localparam logic [SLOT_W-1:0] O_SET = 0, O_CLR = 1, O_STAT = 2, O_VEC = 3, O_DEF = 4;
  localparam logic [LVL_W-1:0] LVL_DEF = LVL_W'(NSLOT);

  logic [NSRC-1:0]  en_q;
  logic [CTL_W-1:0] ctl_q   [NSLOT];
  logic [DW-1:0]    vaddr_q [NSLOT];
  logic [DW-1:0]    def_q;
  logic             busy_q;
  logic [LVL_W-1:0] held_q;

  logic [NSRC-1:0]   live;
  logic [NSLOT-1:0]  hit;
  logic [LVL_W-1:0]  win;
  logic [1:0]        region;
  logic [SLOT_W-1:0] idx;
  logic [DW-1:0]     vec_now;
  logic              vec_sel;

  assign live    = src_i & en_q;
  assign region  = addr_i[ADDR_W-1 -: 2];
  assign idx     = addr_i[SLOT_W-1:0];
  assign vec_sel = (region == RG_CMN) && (idx == O_VEC);
  assign irq_o   = (|live) && !busy_q;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign hit[s] = ctl_q[s][SRC_W] && live[ctl_q[s][SRC_W-1:0]];
  end

  always_comb begin
    win = LVL_DEF;
    for (int s = NSLOT - 1; s >= 0; s--)
      if (hit[s]) win = LVL_W'(s);
  end

  function automatic logic [DW-1:0] addr_of(input logic [LVL_W-1:0] lvl);
    return (lvl == LVL_DEF) ? def_q : vaddr_q[lvl[SLOT_W-1:0]];
  endfunction

  assign vec_now = busy_q ? addr_of(held_q) : addr_of(win);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      def_q  <= '0;
      busy_q <= 1'b0;
      held_q <= '0;
      for (int s = 0; s < NSLOT; s++) begin
        ctl_q[s]   <= '0;
        vaddr_q[s] <= '0;
      end
    end else begin
      if (wr_en_i) begin
        case (region)
          RG_CMN: case (idx)
            O_SET: en_q  <= en_q | wdata_i[NSRC-1:0];
            O_CLR: en_q  <= en_q & ~wdata_i[NSRC-1:0];
            O_DEF: def_q <= wdata_i;
            default: ;
          endcase
          RG_CTL: ctl_q[idx]   <= wdata_i[CTL_W-1:0];
          RG_ADR: vaddr_q[idx] <= wdata_i;
          default: ;
        endcase
      end
      if (wr_en_i && vec_sel)
        busy_q <= 1'b0;
      else if (rd_en_i && vec_sel && !busy_q && (|live)) begin
        busy_q <= 1'b1;
        held_q <= win;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (region)
      RG_CMN: case (idx)
        O_SET:   rdata_o = DW'(en_q);
        O_STAT:  rdata_o = DW'(live);
        O_VEC:   rdata_o = vec_now;
        O_DEF:   rdata_o = def_q;
        default: ;
      endcase
      RG_CTL:  rdata_o = DW'(ctl_q[idx]);
      RG_ADR:  rdata_o = vaddr_q[idx];
      default: ;
    endcase
  end
endmodule

// File: rtl/vic_core_chk.sv
module vic_core_chk #(
  parameter int NSRC   = 32,
  parameter int DW     = 32,
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NSRC-1:0]   src_i,
  input logic [NSRC-1:0]   en_q,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DW-1:0]     rdata_o,
  input logic              irq_o
);
  localparam logic [ADDR_W-1:0] VEC_A = ADDR_W'(3);
  logic vrd, vwr;
  assign vrd = rd_en_i && (addr_i == VEC_A);
  assign vwr = wr_en_i && (addr_i == VEC_A);

  p_rst_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !irq_o);

  p_irq_has_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |(src_i & en_q));

  p_hold_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vrd && irq_o && !wr_en_i) |=> !irq_o);

  p_hold_value_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vrd && irq_o && !wr_en_i) ##1 (vrd && !wr_en_i) |-> rdata_o == $past(rdata_o));

  p_ack_reopen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vwr ##1 (|(src_i & en_q)) |-> irq_o);
endmodule

bind vic_core vic_core_chk #(.NSRC(NSRC), .DW(DW), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .en_q(en_q),
  .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i),
  .rdata_o(rdata_o), .irq_o(irq_o)
);

// File: tb/test_vic_core.sv
`timescale 1ns/1ps
module test_vic_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  logic [31:0] got_q[$];
  string       tag_q[$];
  event        got_ev;

  localparam logic [31:0] DEF = 32'hDEF0_0000;

  always #2.5 clk = ~clk;

  vic_core i_vic_core (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] slot_addr(int s);
    return 32'h1000 + 32'(s) * 32'h100;
  endfunction

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string t);
    @(negedge clk); rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    #1 got_q.push_back(rdata); -> got_ev;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk); #1;
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s irq actual=%0b expected=%0b", t, irq, e);
    end
  endtask

  initial forever begin
    @(got_ev);
    while (got_q.size() > 0) begin
      logic [31:0] g, e; string t;
      g = got_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
      checks++;
      if (g !== e) begin
        fails++;
        $display("FAIL %s rdata actual=%h expected=%h", t, g, e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(5ns * 20000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1
    chk_irq(1'b0, "R1");
    rd(6'h00, 32'h0, "R1");
    rd(6'h03, 32'h0, "R1");
    wr(6'h04, DEF);
    for (int s = 0; s < 16; s++) wr(6'h20 + 6'(s), slot_addr(s));
    rd(6'h23, slot_addr(3), "R4");
    // R2 / R3
    wr(6'h00, 32'h0002_0000);
    rd(6'h00, 32'h0002_0000, "R2");
    wr(6'h00, 32'h0000_4040);
    rd(6'h00, 32'h0002_4040, "R2");
    wr(6'h01, 32'h0000_0040);
    rd(6'h00, 32'h0002_4000, "R3");
    // R4 bindings
    wr(6'h11, 32'h20 | 17);
    wr(6'h14, 32'h20 | 14);
    wr(6'h17, 32'h20 | 6);
    wr(6'h10, 32'h00 | 15);
    rd(6'h11, 32'h31, "R4");
    // R5: request on a disabled source
    src = 32'h0000_0040;
    chk_irq(1'b0, "R5");
    rd(6'h02, 32'h0, "R10");
    // R7: enabled source bound only to a disabled slot
    wr(6'h00, 32'h0000_8000);
    src = 32'h0000_8000;
    chk_irq(1'b1, "R5");
    rd(6'h03, DEF, "R7");
    chk_irq(1'b0, "R8");
    wr(6'h03, 32'h0);
    chk_irq(1'b1, "R9");
    src = 32'h0;
    chk_irq(1'b0, "R5");
    // R6: two requests, lower slot wins
    src = 32'h0002_4000;
    rd(6'h02, 32'h0002_4000, "R10");
    chk_irq(1'b1, "R5");
    rd(6'h03, slot_addr(1), "R6");
    chk_irq(1'b0, "R8");
    src = 32'h0000_4000;
    rd(6'h03, slot_addr(1), "R8");
    wr(6'h03, 32'h0);
    chk_irq(1'b1, "R9");
    rd(6'h03, slot_addr(4), "R9");
    wr(6'h03, 32'h0);
    src = 32'h0;
    // R8: higher priority arrives during service
    src = 32'h0000_4000;
    rd(6'h03, slot_addr(4), "R6");
    src = 32'h0002_4000;
    chk_irq(1'b0, "R8");
    rd(6'h03, slot_addr(4), "R8");
    wr(6'h03, 32'h0);
    chk_irq(1'b1, "R9");
    rd(6'h03, slot_addr(1), "R9");
    wr(6'h03, 32'h0);
    src = 32'h0;
    // R7: nothing pending, read does not start a service
    rd(6'h03, DEF, "R7");
    chk_irq(1'b0, "R7");
    src = 32'h0000_4000;
    chk_irq(1'b1, "R7");
    rd(6'h03, slot_addr(4), "R7");
    wr(6'h03, 32'h0);
    src = 32'h0;
    // R4: disabling slot 1 sends source 17 to the fallback
    wr(6'h11, 32'h00 | 17);
    src = 32'h0002_0000;
    chk_irq(1'b1, "R4");
    rd(6'h03, DEF, "R4");
    wr(6'h03, 32'h0);
    // R4: rebinding source 17 to slot 2
    wr(6'h12, 32'h20 | 17);
    rd(6'h03, slot_addr(2), "R4");
    wr(6'h03, 32'h0);
    // R3: clearing enable silences the source
    wr(6'h01, 32'h0002_0000);
    chk_irq(1'b0, "R3");
    rd(6'h02, 32'h0, "R10");
    src = 32'h0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule